// File: doc/BRIEF.md
# I2C Slave Register Interface

This block is an I2C-bus target that fronts a bank of 8-bit control registers and one read-only status byte. The SCL and SDA pins are oversampled in the system clock domain through a flop chain. START and STOP are decoded from the synchronised lines. The block drives SDA only through an open-drain pull-down enable, and it acknowledges bytes addressed to its fixed 7-bit device address.

A write transaction carries a register-select byte and then data. If the top bit of the register-select byte is clear, each data byte is written to the register named just before it, and the master may alternate select and data bytes as often as it likes before STOP. If that top bit is set, the low seven bits give a starting register, and every later byte up to STOP is written to the next register in turn. The register pointer wraps from 127 to 0. A read transaction has no select phase: the slave acknowledges the address and then shifts out the status byte presented on its read input.

The register bank sees a single-cycle write strobe that comes with a 7-bit register number and a data byte.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, and with an idle bus, `sda_oe` is 0 and `wr_stb` is 0.
- R2: After a START, the slave takes a 7-bit device address MSB first and then a direction bit (0 write, 1 read). If the address equals `DEV_ADDR`, it pulls SDA low for the whole high phase of the ninth SCL pulse.
- R3: A non-matching address gets no acknowledge. SDA is not driven and no write strobe occurs for any later byte until the next START. A START that follows then works normally.
- R4: In a write, the first byte after the address is a register-select byte. If its bit 7 is 0, the next byte is written to register select[6:0]. Both bytes are acknowledged.
- R5: With bit 7 of the select byte at 0, select and data bytes may alternate any number of times before STOP, and each data byte goes to the select byte just before it.
- R6: With bit 7 of the select byte at 1, every later byte until STOP is data. The bytes go to consecutive registers starting at select[6:0], and the register number wraps from 127 to 0.
- R7: In a read, after acknowledging the address, the slave shifts out `rd_byte` MSB first, one bit per SCL pulse, changing SDA only while SCL is low. It releases SDA for the ninth pulse, when the master answers.
- R8: A STOP at any point releases SDA and returns the slave to idle. A byte that is only partly received is never written, and a new transaction is then served.
- R9: A repeated START in the middle of a byte restarts address reception, and the partial byte is not written.
- R10: `wr_stb` is high for exactly one system clock cycle for each complete data byte, and at no other time.
- R11: There is no timeout. If SCL stalls for an arbitrarily long time inside a byte, reception resumes where it stopped once clocking continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level (asynchronous) |
| sda_i | input | 1 | SDA pin level (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_stb | output | 1 | One-cycle register write pulse |
| wr_addr | output | 7 | Register number for the write |
| wr_data | output | 8 | Data byte for the write |
| rd_byte | input | 8 | Status byte returned by a read |

## Verification
The bench aims at the byte boundaries where a slave most often goes wrong.

- **Pointer wrap:** the auto-increment burst crosses from register 127 to 0. A pointer that was too wide would write a register outside the bank instead of register 0.
- **Partial byte on STOP or repeated START:** the bench cuts a data byte short with a STOP and, separately, with a repeated START. A slave that wrote too early would produce a stray strobe, and one that failed to restart would miss the next address.
- **Foreign address:** the bench sends an address that does not match, then data bytes. A slave that did not stay silent would acknowledge or strobe those bytes.
- **Stalled SCL:** the bench holds SCL low in the middle of a byte for thousands of cycles. A slave with a hidden timeout would lose the byte.
- **Read bit order and release:** the read checks the bit order and that SDA is released at the master's answer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam int BYTE_W = 8;
   localparam int REG_W  = 7;
   localparam int CNT_W  = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SEL,
      ST_SEL_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_TX,
      ST_SKIP
   } i2cs_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [DEPTH-1:0] scl_q, sda_q;
   logic             scl_d, sda_d;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= '1;
               sda_q <= '1;
            end else begin
               scl_q <= scl_i;
               sda_q <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= '1;
               sda_q <= '1;
            end else begin
               scl_q <= {scl_q[DEPTH-2:0], scl_i};
               sda_q <= {sda_q[DEPTH-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_s     = scl_q[DEPTH-1];
   assign sda_s     = sda_q[DEPTH-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_evt = scl_s & scl_d & ~sda_s & sda_d;
   assign stop_evt  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
   import i2cs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              rise,
   input  logic              adv,
   input  logic              tx_mode,
   input  logic              sda_bit,
   output logic [BYTE_W-1:0] rx_byte,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              tx_nxt
);
   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (load) begin
         sh  <= load_val;
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else begin
         if (rise) begin
            cnt <= cnt + 1'b1;
            if (!tx_mode) sh <= {sh[BYTE_W-2:0], sda_bit};
         end
         if (adv) sh <= {sh[BYTE_W-2:0], 1'b1};
      end
   end

   assign rx_byte = sh;
   assign bit_cnt = cnt;
   assign tx_nxt  = sh[BYTE_W-2];
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
   import i2cs_pkg::*;
#(
   parameter logic [REG_W-1:0] DEV_ADDR = 7'h3A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic              tx_nxt,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              clr,
   output logic              load,
   output logic              adv,
   output logic              tx_mode,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [REG_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              in_skip
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   i2cs_state_e      st;
   logic             rw_q, burst_q, oe_q, stb_q;
   logic [REG_W-1:0] ptr_q, addr_q;
   logic [BYTE_W-1:0] data_q;
   logic             byte_done;

   assign byte_done = scl_fall && (bit_cnt == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         rw_q    <= 1'b0;
         burst_q <= 1'b0;
         oe_q    <= 1'b0;
         stb_q   <= 1'b0;
         ptr_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         stb_q <= 1'b0;
         if (stop_evt) begin
            st   <= ST_IDLE;
            oe_q <= 1'b0;
         end else if (start_evt) begin
            st   <= ST_ADDR;
            oe_q <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR: if (byte_done) begin
                  if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                     st   <= ST_ADDR_ACK;
                     oe_q <= 1'b1;
                     rw_q <= rx_byte[0];
                  end else begin
                     st <= ST_SKIP;
                  end
               end
               ST_ADDR_ACK: if (scl_fall) begin
                  if (rw_q) begin
                     st   <= ST_TX;
                     oe_q <= ~rd_byte[BYTE_W-1];
                  end else begin
                     st   <= ST_SEL;
                     oe_q <= 1'b0;
                  end
               end
               ST_SEL: if (byte_done) begin
                  st      <= ST_SEL_ACK;
                  oe_q    <= 1'b1;
                  burst_q <= rx_byte[BYTE_W-1];
                  ptr_q   <= rx_byte[REG_W-1:0];
               end
               ST_SEL_ACK: if (scl_fall) begin
                  st   <= ST_DATA;
                  oe_q <= 1'b0;
               end
               ST_DATA: if (byte_done) begin
                  st     <= ST_DATA_ACK;
                  oe_q   <= 1'b1;
                  stb_q  <= 1'b1;
                  addr_q <= ptr_q;
                  data_q <= rx_byte;
                  if (burst_q) ptr_q <= ptr_q + 1'b1;
               end
               ST_DATA_ACK: if (scl_fall) begin
                  oe_q <= 1'b0;
                  st   <= burst_q ? ST_DATA : ST_SEL;
               end
               ST_TX: if (scl_fall) begin
                  if (bit_cnt == FULL) begin
                     st   <= ST_SKIP;
                     oe_q <= 1'b0;
                  end else begin
                     oe_q <= ~tx_nxt;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      clr  = start_evt;
      load = 1'b0;
      if (scl_fall) begin
         unique case (st)
            ST_ADDR_ACK: begin
               load = rw_q;
               clr  = clr | ~rw_q;
            end
            ST_SEL_ACK, ST_DATA_ACK: clr = 1'b1;
            default: ;
         endcase
      end
   end

   assign adv     = scl_fall && (st == ST_TX);
   assign tx_mode = (st == ST_TX);
   assign sda_oe  = oe_q;
   assign wr_stb  = stb_q;
   assign wr_addr = addr_q;
   assign wr_data = data_q;
   assign in_skip = (st == ST_SKIP);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
   import i2cs_pkg::*;
#(
   parameter logic [REG_W-1:0] DEV_ADDR   = 7'h3A,
   parameter int               SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [REG_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] rd_byte
);
   initial begin : p_param_chk
      if (SYNC_DEPTH < 2) $error("SYNC_DEPTH must be at least 2");
      if (BYTE_W >= (1 << CNT_W)) $error("bit counter too narrow for BYTE_W");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic clr, load, adv, tx_mode, tx_nxt, in_skip;
   logic [BYTE_W-1:0] rx_byte;
   logic [CNT_W-1:0]  bit_cnt;

   i2cs_line_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   i2cs_byte_engine u_eng (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_val(rd_byte),
      .rise(scl_rise), .adv(adv), .tx_mode(tx_mode), .sda_bit(sda_s),
      .rx_byte(rx_byte), .bit_cnt(bit_cnt), .tx_nxt(tx_nxt)
   );

   i2cs_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_evt(start_evt),
      .stop_evt(stop_evt), .rx_byte(rx_byte), .bit_cnt(bit_cnt), .tx_nxt(tx_nxt),
      .rd_byte(rd_byte), .clr(clr), .load(load), .adv(adv), .tx_mode(tx_mode),
      .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .in_skip(in_skip)
   );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_evt,
   input logic stop_evt,
   input logic sda_oe,
   input logic wr_stb,
   input logic in_skip
);
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);

   a_r9_start_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (!wr_stb && !sda_oe));

   a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      in_skip |-> (!sda_oe && !wr_stb));

   a_r7_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
   .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_stb(wr_stb), .in_skip(in_skip)
);

// File: tb/i2c_reg_slave_bench.sv
`timescale 1ns/1ps
module i2c_reg_slave_bench;
   localparam logic [6:0] DEV = 7'h3A;
   localparam int Q = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, wr_stb;
   logic [6:0] wr_addr;
   logic [7:0] wr_data, rd_byte;
   logic sda_line;

   int tests = 0, fails = 0;
   int exp_a[$], exp_d[$];
   bit quiet = 1'b0;
   int quiet_viol = 0;
   bit prev_stb = 1'b0;

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_reg_slave #(.DEV_ADDR(DEV)) u_i2c_reg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_byte(rd_byte)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   // reference model of register writes, compared on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (quiet && sda_oe) quiet_viol++;
         if (wr_stb) begin
            chk(!prev_stb, "R10 strobe longer than one cycle", 1, 0);
            if (exp_a.size() == 0) begin
               chk(1'b0, "R10 unexpected write strobe", int'(wr_addr), -1);
            end else begin
               int ea, ed;
               ea = exp_a.pop_front();
               ed = exp_d.pop_front();
               chk(int'(wr_addr) == ea, "R5 write register", int'(wr_addr), ea);
               chk(int'(wr_data) == ed, "R4 write data", int'(wr_data), ed);
            end
         end
         prev_stb <= wr_stb;
      end
   end

   task automatic push(input int a, input int d);
      exp_a.push_back(a);
      exp_d.push_back(d);
   endtask

   task automatic q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b0; q(); scl_m = 1'b0; q();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = v[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
      end
   endtask

   task automatic ack_bit(input bit exp_ack, input string req);
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      chk(sda_line == !exp_ack, req, int'(sda_line), int'(!exp_ack));
      q(); scl_m = 1'b0; q();
   endtask

   task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
      send_bits(v, 8);
      ack_bit(exp_ack, req);
   endtask

   task automatic recv_byte(input logic [7:0] exp);
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; q(); scl_m = 1'b1; q(); got[i] = sda_line; q(); scl_m = 1'b0; q();
      end
      chk(got == exp, "R7 read byte MSB first", int'(got), int'(exp));
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      chk(sda_line == 1'b1, "R7 SDA released at master answer", int'(sda_line), 1);
      q(); scl_m = 1'b0; q();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      report();
      $finish;
   end

   initial begin : main
      rd_byte = 8'h96;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (50) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
      chk(wr_stb == 1'b0, "R1 wr_stb after reset", int'(wr_stb), 0);

      // R2 / R4 basic write
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R2 address acknowledge");
      push(8'h05, 8'hA3);
      send_byte(8'h05, 1'b1, "R4 select acknowledge");
      send_byte(8'hA3, 1'b1, "R4 data acknowledge");
      bus_stop();

      // R5 repeated select/data pairs
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R2 address acknowledge");
      push(8'h10, 8'h11); send_byte(8'h10, 1'b1, "R5 ack"); send_byte(8'h11, 1'b1, "R5 ack");
      push(8'h22, 8'h5C); send_byte(8'h22, 1'b1, "R5 ack"); send_byte(8'h5C, 1'b1, "R5 ack");
      push(8'h7F, 8'hFF); send_byte(8'h7F, 1'b1, "R5 ack"); send_byte(8'hFF, 1'b1, "R5 ack");
      bus_stop();

      // R6 auto-increment burst across the 127 -> 0 wrap
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R2 address acknowledge");
      send_byte(8'hFE, 1'b1, "R6 burst select ack");
      push(8'h7E, 8'h01); send_byte(8'h01, 1'b1, "R6 burst data ack");
      push(8'h7F, 8'h02); send_byte(8'h02, 1'b1, "R6 burst data ack");
      push(8'h00, 8'h03); send_byte(8'h03, 1'b1, "R6 burst data ack after wrap");
      push(8'h01, 8'h04); send_byte(8'h04, 1'b1, "R6 burst data ack");
      bus_stop();

      // R3 foreign address, then recovery on a repeated START
      bus_start();
      quiet = 1'b1;
      send_byte({7'h12, 1'b0}, 1'b0, "R3 no ack for foreign address");
      send_byte(8'h06, 1'b0, "R3 ignored byte not acked");
      send_byte(8'h99, 1'b0, "R3 ignored byte not acked");
      quiet = 1'b0;
      chk(quiet_viol == 0, "R3 SDA never driven while ignoring", quiet_viol, 0);
      bus_rstart();
      send_byte({DEV, 1'b0}, 1'b1, "R3 address acked after new START");
      push(8'h33, 8'h44);
      send_byte(8'h33, 1'b1, "R3 ack"); send_byte(8'h44, 1'b1, "R3 ack");
      bus_stop();

      // R7 reads
      bus_start();
      send_byte({DEV, 1'b1}, 1'b1, "R2 read address acknowledge");
      recv_byte(8'h96);
      bus_stop();
      rd_byte = 8'h3C;
      bus_start();
      send_byte({DEV, 1'b1}, 1'b1, "R2 read address acknowledge");
      recv_byte(8'h3C);
      bus_stop();

      // R8 STOP in the middle of a data byte
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R2 address acknowledge");
      send_byte(8'h03, 1'b1, "R8 select ack");
      send_bits(8'hF0, 4);
      bus_stop();
      repeat (20) @(negedge clk);
      chk(sda_oe == 1'b0, "R8 SDA released after STOP", int'(sda_oe), 0);
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R8 address acked after STOP");
      push(8'h04, 8'h77);
      send_byte(8'h04, 1'b1, "R8 ack"); send_byte(8'h77, 1'b1, "R8 ack");
      bus_stop();

      // R9 repeated START in the middle of a data byte
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R2 address acknowledge");
      send_byte(8'h09, 1'b1, "R9 select ack");
      send_bits(8'hAA, 5);
      bus_rstart();
      send_byte({DEV, 1'b0}, 1'b1, "R9 address acked after repeated START");
      push(8'h0A, 8'h42);
      send_byte(8'h0A, 1'b1, "R9 ack"); send_byte(8'h42, 1'b1, "R9 ack");
      bus_stop();

      // R11 SCL stalled inside a byte
      bus_start();
      send_byte({DEV, 1'b0}, 1'b1, "R2 address acknowledge");
      send_byte(8'h20, 1'b1, "R11 select ack");
      push(8'h20, 8'hB5);
      send_bits(8'hB5, 3);
      repeat (3000) @(negedge clk);
      send_bits(8'hB5 << 3, 5);
      ack_bit(1'b1, "R11 byte acked after stall");
      bus_stop();

      repeat (50) @(negedge clk);
      chk(exp_a.size() == 0, "R10 one strobe per complete data byte", exp_a.size(), 0);
      report();
      $finish;
   end
endmodule